// File: doc/BRIEF.md
# Processor Status Flag Register

This block keeps the eight-bit status register of a small accumulator-based 8-bit CPU core. It watches a set of strobes from the core's sequencer and rewrites the flags: arithmetic, shift and data-transfer results update the condition flags, a bit-test operation copies two operand bits into the flags, and dedicated set and clear operations change the mode flags. A stack pull reloads the whole register. The block also supplies the byte that a stack push stores, forcing the break marker into that copy during a software interrupt.

The live flag vector is a register output. The pushed byte and the interrupt-enable qualifier are derived from it. The ALU, decimal adder, stack pointer and instruction decoder sit outside the block, and the strobe interface below stands in for them.

Top module: `status_flag_reg`

## Requirements
- R1: Synchronous active-high reset loads the flag vector with 8'h04, so only the interrupt mask bit (bit 2) is 1 and irq_ok is 0.
- R2: Bit positions are carry 0, zero 1, interrupt mask 2, decimal 3, break 4, memory-mode 5, overflow 6, negative 7. An arithmetic update with bit 3 at 0 sets carry from alu_carry, zero to (alu_res == 0), negative to alu_res[7] and overflow from alu_ovf.
- R3: An arithmetic update with bit 3 at 1 updates only carry. Zero, overflow and negative keep their values.
- R4: A shift update sets carry, zero and negative from the result and leaves overflow unchanged, whatever the decimal bit holds.
- R5: A transfer update sets zero and negative from alu_res and leaves every other flag unchanged.
- R6: A bit-test update copies bit_operand[6] into overflow and bit_operand[7] into negative. All other flags are kept.
- R7: flag_op is one-hot. Index 0 sets carry, 1 clears carry, 2 sets the mask, 3 clears the mask, 4 sets decimal, 5 clears decimal, 6 sets memory-mode, 7 clears memory-mode, and 8 clears overflow. Only the addressed flag changes.
- R8: Bit 4 of the live vector reads 0 at all times. A stack pull loads every other bit from pull_data.
- R9: push_byte equals the live vector, with bit 4 forced to 1 whenever brk_push is high.
- R10: irq_ok is 1 exactly when the interrupt mask bit is 0.
- R11: When strobes coincide, a stack pull wins over a flag operation, and a flag operation wins over every result update in that cycle.
- R12: A flag_op with more than one bit set is discarded. The cycle then behaves as if flag_op were zero.
- R13: Among result updates in the same cycle, arithmetic wins over shift, shift wins over bit-test, and bit-test wins over transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_res | input | 8 | Result byte from the ALU |
| alu_carry | input | 1 | Carry or borrow out |
| alu_ovf | input | 1 | Signed overflow of the operation |
| arith_upd | input | 1 | Arithmetic result update |
| shift_upd | input | 1 | Shift or rotate result update |
| xfer_upd | input | 1 | Data-transfer result update |
| bit_test | input | 1 | Bit-test update |
| bit_operand | input | 8 | Memory operand of the bit test |
| flag_op | input | 9 | One-hot set/clear operation |
| pull_load | input | 1 | Load the register from the stack |
| pull_data | input | 8 | Byte pulled from the stack |
| brk_push | input | 1 | Software-interrupt push in progress |
| flags | output | 8 | Live flag vector |
| push_byte | output | 8 | Byte to store on a push |
| irq_ok | output | 1 | Hardware interrupts accepted |

## Verification
The hardest cases to reach are coincident strobes. These are cycles where a pull, a flag operation and several result updates all arrive together, possibly with a malformed multi-bit flag_op, and the block has to pick exactly one winner. A random core strobe pattern seldom lines them up with the decimal bit set. The bench therefore drives directed collisions, including a decimal-mode arithmetic update that meets a shift. It then runs long random sequences that raise several strobes at once, comparing against a behavioural model every cycle.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int FLAG_W = 8;
  localparam int OP_W   = 9;

  localparam int C_BIT = 0;
  localparam int Z_BIT = 1;
  localparam int I_BIT = 2;
  localparam int D_BIT = 3;
  localparam int B_BIT = 4;
  localparam int T_BIT = 5;
  localparam int V_BIT = 6;
  localparam int N_BIT = 7;
  localparam int SIGN_BIT = FLAG_W - 1;

  localparam logic [FLAG_W-1:0] RESET_FLAGS = FLAG_W'(1) << I_BIT;
  localparam logic [FLAG_W-1:0] TIED_ZERO   = FLAG_W'(1) << B_BIT;

  typedef struct packed {
    logic [FLAG_W-1:0] set_m;
    logic [FLAG_W-1:0] clr_m;
  } flag_mask_t;

  // flag addressed by each flag_op index
  function automatic int op_flag(input int k);
    case (k)
      0, 1:    return C_BIT;
      2, 3:    return I_BIT;
      4, 5:    return D_BIT;
      6, 7:    return T_BIT;
      default: return V_BIT;
    endcase
  endfunction

  // even indices below 8 set, all others clear
  function automatic logic op_sets(input int k);
    return (k < 8) && ((k % 2) == 0);
  endfunction
endpackage

// File: rtl/psr_op_decode.sv
module psr_op_decode
  import psr_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output flag_mask_t      mask,
  output logic            op_valid
);
  assign op_valid = (op != '0) && ((op & (op - 1'b1)) == '0);

  always_comb begin
    mask = '0;
    if (op_valid) begin
      for (int k = 0; k < OP_W; k++) begin
        if (op[k]) begin
          if (op_sets(k)) mask.set_m[op_flag(k)] = 1'b1;
          else            mask.clr_m[op_flag(k)] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/psr_result_eval.sv
module psr_result_eval
  import psr_pkg::*;
(
  input  logic [FLAG_W-1:0] cur,
  input  logic [FLAG_W-1:0] alu_res,
  input  logic              alu_carry,
  input  logic              alu_ovf,
  input  logic              arith_upd,
  input  logic              shift_upd,
  input  logic              xfer_upd,
  input  logic              bit_test,
  input  logic [FLAG_W-1:0] bit_operand,
  output logic [FLAG_W-1:0] nxt,
  output logic              upd
);
  logic res_zero;
  assign res_zero = (alu_res == '0);

  always_comb begin
    nxt = cur;
    upd = 1'b1;
    if (arith_upd) begin
      nxt[C_BIT] = alu_carry;
      if (!cur[D_BIT]) begin
        nxt[Z_BIT] = res_zero;
        nxt[N_BIT] = alu_res[SIGN_BIT];
        nxt[V_BIT] = alu_ovf;
      end
    end else if (shift_upd) begin
      nxt[C_BIT] = alu_carry;
      nxt[Z_BIT] = res_zero;
      nxt[N_BIT] = alu_res[SIGN_BIT];
    end else if (bit_test) begin
      nxt[V_BIT] = bit_operand[V_BIT];
      nxt[N_BIT] = bit_operand[N_BIT];
    end else if (xfer_upd) begin
      nxt[Z_BIT] = res_zero;
      nxt[N_BIT] = alu_res[SIGN_BIT];
    end else begin
      upd = 1'b0;
    end
  end
endmodule

// File: rtl/psr_flag_bank.sv
module psr_flag_bank
  import psr_pkg::*;
#(
  parameter logic [FLAG_W-1:0] RST_VAL  = RESET_FLAGS,
  parameter logic [FLAG_W-1:0] ZERO_MSK = TIED_ZERO
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [FLAG_W-1:0] load_val,
  input  logic              mask_en,
  input  flag_mask_t        mask,
  input  logic              res_en,
  input  logic [FLAG_W-1:0] res_val,
  output logic [FLAG_W-1:0] q
);
  for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
    if (ZERO_MSK[i]) begin : g_tied
      assign q[i] = 1'b0;
    end else begin : g_ff
      logic bit_q;
      always_ff @(posedge clk) begin
        if (rst)                                   bit_q <= RST_VAL[i];
        else if (load_en)                          bit_q <= load_val[i];
        else if (mask_en) begin
          if (mask.set_m[i] || mask.clr_m[i])      bit_q <= mask.set_m[i];
        end
        else if (res_en)                           bit_q <= res_val[i];
      end
      assign q[i] = bit_q;
    end
  end
endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg
  import psr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [FLAG_W-1:0] alu_res,
  input  logic              alu_carry,
  input  logic              alu_ovf,
  input  logic              arith_upd,
  input  logic              shift_upd,
  input  logic              xfer_upd,
  input  logic              bit_test,
  input  logic [FLAG_W-1:0] bit_operand,
  input  logic [OP_W-1:0]   flag_op,
  input  logic              pull_load,
  input  logic [FLAG_W-1:0] pull_data,
  input  logic              brk_push,
  output logic [FLAG_W-1:0] flags,
  output logic [FLAG_W-1:0] push_byte,
  output logic              irq_ok
);
  flag_mask_t        op_mask;
  logic              op_valid;
  logic [FLAG_W-1:0] res_nxt;
  logic              res_upd;

  psr_op_decode u_dec (
    .op       (flag_op),
    .mask     (op_mask),
    .op_valid (op_valid)
  );

  psr_result_eval u_eval (
    .cur         (flags),
    .alu_res     (alu_res),
    .alu_carry   (alu_carry),
    .alu_ovf     (alu_ovf),
    .arith_upd   (arith_upd),
    .shift_upd   (shift_upd),
    .xfer_upd    (xfer_upd),
    .bit_test    (bit_test),
    .bit_operand (bit_operand),
    .nxt         (res_nxt),
    .upd         (res_upd)
  );

  psr_flag_bank #(
    .RST_VAL  (RESET_FLAGS),
    .ZERO_MSK (TIED_ZERO)
  ) u_bank (
    .clk      (clk),
    .rst      (rst),
    .load_en  (pull_load),
    .load_val (pull_data),
    .mask_en  (op_valid),
    .mask     (op_mask),
    .res_en   (res_upd),
    .res_val  (res_nxt),
    .q        (flags)
  );

  assign push_byte = flags | (brk_push ? TIED_ZERO : '0);
  assign irq_ok    = ~flags[I_BIT];
endmodule

// File: rtl/psr_checker.sv
module psr_checker (
  input logic       clk,
  input logic       rst,
  input logic       arith_upd,
  input logic [8:0] flag_op,
  input logic       pull_load,
  input logic [7:0] pull_data,
  input logic       brk_push,
  input logic [7:0] flags,
  input logic [7:0] push_byte
);
  assert_reset_value_R1: assert property (@(posedge clk)
    rst |=> flags == 8'h04);

  assert_break_zero_R8: assert property (@(posedge clk) disable iff (rst)
    flags[4] == 1'b0);

  assert_pull_wins_R11: assert property (@(posedge clk) disable iff (rst)
    pull_load |=> flags == ($past(pull_data) & 8'hEF));

  assert_clear_ovf_R7: assert property (@(posedge clk) disable iff (rst)
    (!pull_load && flag_op == 9'h100) |=> !flags[6]);

  assert_decimal_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!pull_load && flag_op == 9'h000 && arith_upd && flags[3])
      |=> (flags[7:6] == $past(flags[7:6])) && (flags[1] == $past(flags[1])));

  assert_push_marker_R9: assert property (@(posedge clk) disable iff (rst)
    brk_push |-> push_byte[4] && ((push_byte & 8'hEF) == flags));
endmodule

bind status_flag_reg psr_checker u_psr_checker (
  .clk       (clk),
  .rst       (rst),
  .arith_upd (arith_upd),
  .flag_op   (flag_op),
  .pull_load (pull_load),
  .pull_data (pull_data),
  .brk_push  (brk_push),
  .flags     (flags),
  .push_byte (push_byte)
);

// File: tb/test_status_flag_reg.sv
`timescale 1ns/1ps
module test_status_flag_reg;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] alu_res = 8'h00;
  logic       alu_carry = 1'b0, alu_ovf = 1'b0;
  logic       arith_upd = 1'b0, shift_upd = 1'b0, xfer_upd = 1'b0, bit_test = 1'b0;
  logic [7:0] bit_operand = 8'h00;
  logic [8:0] flag_op = 9'h000;
  logic       pull_load = 1'b0;
  logic [7:0] pull_data = 8'h00;
  logic       brk_push = 1'b0;
  logic [7:0] flags, push_byte;
  logic       irq_ok;

  int checks = 0;
  int errors = 0;
  logic [7:0] model = 8'h04;

  always #2.5 clk = ~clk;

  status_flag_reg i_status_flag_reg (
    .clk(clk), .rst(rst), .alu_res(alu_res), .alu_carry(alu_carry),
    .alu_ovf(alu_ovf), .arith_upd(arith_upd), .shift_upd(shift_upd),
    .xfer_upd(xfer_upd), .bit_test(bit_test), .bit_operand(bit_operand),
    .flag_op(flag_op), .pull_load(pull_load), .pull_data(pull_data),
    .brk_push(brk_push), .flags(flags), .push_byte(push_byte), .irq_ok(irq_ok)
  );

  function automatic logic [7:0] model_next(input logic [7:0] f);
    logic [7:0] n;
    n = f;
    if (pull_load) begin
      n = pull_data;
      n[4] = 1'b0;
    end else if ($countones(flag_op) == 1) begin
      for (int k = 0; k < 9; k++) begin
        if (flag_op[k]) begin
          case (k)
            0: n[0] = 1; 1: n[0] = 0; 2: n[2] = 1; 3: n[2] = 0;
            4: n[3] = 1; 5: n[3] = 0; 6: n[5] = 1; 7: n[5] = 0;
            default: n[6] = 0;
          endcase
        end
      end
    end else if (arith_upd) begin
      n[0] = alu_carry;
      if (f[3] == 1'b0) begin
        n[1] = (alu_res == 0);
        n[7] = alu_res[7];
        n[6] = alu_ovf;
      end
    end else if (shift_upd) begin
      n[0] = alu_carry; n[1] = (alu_res == 0); n[7] = alu_res[7];
    end else if (bit_test) begin
      n[6] = bit_operand[6]; n[7] = bit_operand[7];
    end else if (xfer_upd) begin
      n[1] = (alu_res == 0); n[7] = alu_res[7];
    end
    return n;
  endfunction

  task automatic check8(input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    alu_res = 0; alu_carry = 0; alu_ovf = 0;
    arith_upd = 0; shift_upd = 0; xfer_upd = 0; bit_test = 0;
    bit_operand = 0; flag_op = 0; pull_load = 0; pull_data = 0; brk_push = 0;
  endtask

  // inputs already driven after a falling edge
  task automatic step(input string req);
    logic [7:0] nxt;
    #1;
    check8("R9", "push_byte", push_byte, brk_push ? (model | 8'h10) : model);
    nxt = model_next(model);
    @(negedge clk);
    model = nxt;
    check8(req, "flags", flags, model);
    check8("R10", "irq_ok", {7'd0, irq_ok}, {7'd0, ~model[2]});
    idle();
  endtask

  function automatic string tag_for();
    if (pull_load) return "R8";
    if (flag_op != 0 && $countones(flag_op) != 1) return "R12";
    if (flag_op != 0) return "R7";
    if (arith_upd) return model[3] ? "R3" : "R2";
    if (shift_upd) return "R4";
    if (bit_test) return "R6";
    if (xfer_upd) return "R5";
    return "R11";
  endfunction

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle();
    rst = 1;
    repeat (3) @(negedge clk);
    check8("R1", "reset flags", flags, 8'h04);
    check8("R1", "reset irq_ok", {7'd0, irq_ok}, 8'h00);
    rst = 0;

    // R2 binary arithmetic: signed overflow into negative
    alu_res = 8'h80; alu_ovf = 1; arith_upd = 1; step("R2");
    alu_res = 8'h00; alu_carry = 1; arith_upd = 1; step("R2");
    // R7 every strobe index
    for (int k = 0; k < 9; k++) begin
      flag_op = 9'(1) << k; step("R7");
    end
    flag_op = 9'h010; step("R7");               // decimal on
    // R3 decimal arithmetic holds Z,V,N
    alu_res = 8'h00; alu_carry = 0; alu_ovf = 1; arith_upd = 1; step("R3");
    // R13 decimal arithmetic still beats a shift
    alu_res = 8'h00; alu_carry = 1; arith_upd = 1; shift_upd = 1; step("R13");
    // R4 shift in decimal mode
    alu_res = 8'hC0; alu_carry = 0; shift_upd = 1; step("R4");
    flag_op = 9'h020; step("R7");               // decimal off
    // R6 bit test, then R13 bit test beats transfer
    bit_operand = 8'h40; bit_test = 1; step("R6");
    bit_operand = 8'h80; bit_test = 1; xfer_upd = 1; alu_res = 8'h00; step("R13");
    // R5 transfer
    alu_res = 8'h00; xfer_upd = 1; step("R5");
    // R11 strobe beats arithmetic, pull beats strobe
    flag_op = 9'h001; arith_upd = 1; alu_res = 8'h55; step("R11");
    pull_load = 1; pull_data = 8'hFF; flag_op = 9'h008; arith_upd = 1; step("R11");
    // R8 pull with break bit set in data
    pull_load = 1; pull_data = 8'h10; step("R8");
    // R12 malformed strobe: arithmetic proceeds
    flag_op = 9'h003; arith_upd = 1; alu_res = 8'h00; alu_ovf = 1; step("R12");
    // R9 software-interrupt push
    brk_push = 1; step("R9");

    for (int n = 0; n < 3000; n++) begin
      alu_res     = 8'($urandom);
      alu_carry   = 1'($urandom);
      alu_ovf     = 1'($urandom);
      arith_upd   = ($urandom % 4) == 0;
      shift_upd   = ($urandom % 4) == 0;
      xfer_upd    = ($urandom % 4) == 0;
      bit_test    = ($urandom % 4) == 0;
      bit_operand = 8'($urandom);
      case ($urandom % 6)
        0: flag_op = 9'(1) << ($urandom % 9);
        1: flag_op = 9'($urandom);
        default: flag_op = 9'h000;
      endcase
      pull_load   = ($urandom % 12) == 0;
      pull_data   = 8'($urandom);
      brk_push    = ($urandom % 3) == 0;
      step(tag_for());
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule